// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block holds the coherence state of every line of a small direct-mapped private cache that sits on a shared snooping bus. Each line is in one of five states: Invalid, Shared, Exclusive, Owned or Modified. A tag is stored next to each state. The block takes local processor reads and writes and works out which bus transaction each one needs. It places that transaction on a request/grant bus port and commits the new line state in the cycle the bus grants it. Requests issued by other caches arrive on a snoop port. The block answers each of them in the same cycle with a shared-line flag and a data-supply flag, and updates the line state at the next clock edge.

The controller keeps no memory of a pending operation between cycles. While the processor holds a request, the block evaluates it again every cycle against the current line state. A snoop that changes the line during a wait therefore changes the bus command that follows. A write miss takes two steps. A fill brings the line in as Exclusive or Shared, and the same held request then becomes a write hit. A dirty line (Owned or Modified) supplies its data to a snooped read directly, and memory is not updated first.

Top module: `moesi_line_ctl`

## Requirements
- R1: After reset every line is Invalid. A snooped read gets neither the shared flag nor the supply flag, and every local access issues a bus read.
- R2: A local read miss whose victim is clean or Invalid raises bus_req with command 0 (read) and the request address. In the granted cycle the line fills as Exclusive when bus_shared is low and as Shared when it is high, and the read is acknowledged in that same cycle.
- R3: A local write miss first fills the line the same way as R2, with no acknowledge. On the next cycle the held write hits. If the line is Exclusive, the write is acknowledged with no bus request and the line becomes Modified.
- R4: A local write that hits a Shared or Owned line raises command 1 (invalidate) with the request address. It is acknowledged only in the granted cycle, and the line then becomes Modified.
- R5: A read hit in any valid state, and a write hit on a Modified line, are acknowledged in the same cycle with no bus request. A write hit on a Modified line leaves it Modified.
- R6: A snooped read (snoop command 0) that hits a valid line asserts snp_shared. snp_supply is asserted only when the line is Modified or Owned. Modified becomes Owned, Exclusive becomes Shared, and Owned and Shared stay as they are.
- R7: A snooped invalidate (snoop command 1) that hits a line sets the line to Invalid, so the next local access to that address misses.
- R8: A local miss whose victim is Modified or Owned first raises command 2 (write-back) with the victim's address. On grant the victim becomes Invalid, and the access then continues as in R2. A miss on an Exclusive or Shared victim issues no write-back.
- R9: A snoop is ignored while bus_gnt is high, and a snooped write-back (command 2) never changes state or raises a response flag.
- R10: In a cycle where an active snoop hits the same set as the local request, the local request makes no acknowledge and no bus request. When no request is issued, bus_cmd reads 3 and bus_addr reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Local access held until acknowledged |
| cpu_write | input | 1 | Local access is a write |
| cpu_addr | input | ADDR_W | Line address, set index in the low IDX_W bits |
| cpu_ack | output | 1 | Local access completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_cmd | output | 2 | 0 read, 1 invalidate, 2 write-back, 3 idle |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_gnt | input | 1 | Bus granted; the transaction takes place this cycle |
| bus_shared | input | 1 | Another cache holds the line being read |
| snp_valid | input | 1 | Snooped request from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the snooped line's data |

## Verification
The bench builds the block with a 4-bit address and 2 index bits. That gives four sets and four tags per set, so every address collides with three others and evictions of each state happen all the time. With this size, directed sequences walk each line through every state change. A long per-cycle sweep then mixes reads, writes, grants, shared replies and snoops on all sixteen addresses. Every output is compared each cycle against a state model kept in the bench.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
    typedef enum logic [2:0] {
        LN_I = 3'd0,
        LN_S = 3'd1,
        LN_E = 3'd2,
        LN_O = 3'd3,
        LN_M = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_INV  = 2'd1,
        CMD_WB   = 2'd2,
        CMD_NONE = 2'd3
    } bus_cmd_e;
endpackage

// File: rtl/moesi_cpu_ctl.sv
module moesi_cpu_ctl
    import moesi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             en,
    input  logic             write,
    input  logic [TAG_W-1:0] rtag,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] ltag,
    input  logic             gnt,
    input  logic             shared_in,
    output logic             ack,
    output logic             breq,
    output bus_cmd_e         bcmd,
    output logic [TAG_W-1:0] btag,
    output logic             upd,
    output line_st_e         nst,
    output logic [TAG_W-1:0] ntag
);
    logic hit;

    always_comb begin
        hit  = (st != LN_I) && (ltag == rtag);
        ack  = 1'b0;
        breq = 1'b0;
        bcmd = CMD_RD;
        btag = rtag;
        upd  = 1'b0;
        nst  = st;
        ntag = ltag;
        if (en) begin
            if (hit) begin
                if (!write) begin
                    ack = 1'b1;
                end else begin
                    case (st)
                        LN_M: ack = 1'b1;
                        LN_E: begin
                            ack = 1'b1;
                            upd = 1'b1;
                            nst = LN_M;
                        end
                        default: begin
                            // Shared or Owned: others may hold copies
                            breq = 1'b1;
                            bcmd = CMD_INV;
                            if (gnt) begin
                                ack = 1'b1;
                                upd = 1'b1;
                                nst = LN_M;
                            end
                        end
                    endcase
                end
            end else if (st == LN_M || st == LN_O) begin
                breq = 1'b1;
                bcmd = CMD_WB;
                btag = ltag;
                if (gnt) begin
                    upd = 1'b1;
                    nst = LN_I;
                end
            end else begin
                breq = 1'b1;
                bcmd = CMD_RD;
                if (gnt) begin
                    upd  = 1'b1;
                    nst  = shared_in ? LN_S : LN_E;
                    ntag = rtag;
                    ack  = !write;
                end
            end
        end
    end
endmodule

// File: rtl/moesi_snoop_ctl.sv
module moesi_snoop_ctl
    import moesi_pkg::*;
#(
    parameter int TAG_W = 12
) (
    input  logic             en,
    input  bus_cmd_e         cmd,
    input  logic [TAG_W-1:0] stag,
    input  line_st_e         st,
    input  logic [TAG_W-1:0] ltag,
    output logic             act,
    output logic             shared,
    output logic             supply,
    output logic             upd,
    output line_st_e         nst
);
    logic hit;

    always_comb begin
        hit    = en && (st != LN_I) && (ltag == stag);
        act    = hit && (cmd == CMD_RD || cmd == CMD_INV);
        shared = hit && (cmd == CMD_RD);
        supply = shared && (st == LN_M || st == LN_O);
        upd    = 1'b0;
        nst    = st;
        if (act) begin
            if (cmd == CMD_INV) begin
                upd = 1'b1;
                nst = LN_I;
            end else if (st == LN_M) begin
                upd = 1'b1;
                nst = LN_O;
            end else if (st == LN_E) begin
                upd = 1'b1;
                nst = LN_S;
            end
        end
    end
endmodule

// File: rtl/moesi_line_ctl.sv
module moesi_line_ctl
    import moesi_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ack,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_supply
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;

    typedef struct packed {
        line_st_e         st;
        logic [TAG_W-1:0] tag;
    } line_t;

    typedef struct packed {
        line_t [SETS-1:0] lines;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] cidx, sidx;
    logic [TAG_W-1:0] ctag, stag;
    line_t            cline, sline;

    assign {ctag, cidx} = cpu_addr;
    assign {stag, sidx} = snp_addr;
    assign cline = ctl_q.lines[cidx];
    assign sline = ctl_q.lines[sidx];

    logic     s_act, s_shared, s_supply, s_upd;
    line_st_e s_nst;

    moesi_snoop_ctl #(.TAG_W(TAG_W)) i_snoop (
        .en     (snp_valid && !bus_gnt),
        .cmd    (bus_cmd_e'(snp_cmd)),
        .stag   (stag),
        .st     (sline.st),
        .ltag   (sline.tag),
        .act    (s_act),
        .shared (s_shared),
        .supply (s_supply),
        .upd    (s_upd),
        .nst    (s_nst)
    );

    logic             c_en, c_ack, c_breq, c_upd;
    bus_cmd_e         c_bcmd;
    line_st_e         c_nst;
    logic [TAG_W-1:0] c_btag, c_ntag;

    // a snoop acting on the same set takes the line this cycle
    assign c_en = cpu_valid && !(s_act && (sidx == cidx));

    moesi_cpu_ctl #(.TAG_W(TAG_W)) i_cpu (
        .en        (c_en),
        .write     (cpu_write),
        .rtag      (ctag),
        .st        (cline.st),
        .ltag      (cline.tag),
        .gnt       (bus_gnt),
        .shared_in (bus_shared),
        .ack       (c_ack),
        .breq      (c_breq),
        .bcmd      (c_bcmd),
        .btag      (c_btag),
        .upd       (c_upd),
        .nst       (c_nst),
        .ntag      (c_ntag)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (c_upd) begin
            ctl_d.lines[cidx].st  = c_nst;
            ctl_d.lines[cidx].tag = c_ntag;
        end
        if (s_upd) begin
            ctl_d.lines[sidx].st = s_nst;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_ack    = c_ack;
    assign bus_req    = c_breq;
    assign bus_cmd    = c_breq ? c_bcmd : CMD_NONE;
    assign bus_addr   = c_breq ? {c_btag, cidx} : '0;
    assign snp_shared = s_shared;
    assign snp_supply = s_supply;
endmodule

// File: rtl/moesi_line_ctl_chk.sv
module moesi_line_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_valid,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ack,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_gnt,
    input logic              snp_shared,
    input logic              snp_supply
);
    a_r5_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_valid);

    a_r4_ack_with_req_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && bus_req) |-> bus_gnt);

    a_r10_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'd3));

    a_r2_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd0) |-> (bus_addr == cpu_addr));

    a_r4_inv_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd1) |-> (bus_addr == cpu_addr));

    a_r8_wb_victim: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == 2'd2) |->
            (bus_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0] && bus_addr != cpu_addr));

    a_r9_grant_mutes_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        bus_gnt |-> (!snp_shared && !snp_supply));

    a_r6_supply_needs_shared: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> snp_shared);
endmodule

bind moesi_line_ctl moesi_line_ctl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_addr   (cpu_addr),
    .cpu_ack    (cpu_ack),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_gnt    (bus_gnt),
    .snp_shared (snp_shared),
    .snp_supply (snp_supply)
);

// File: tb/test_moesi_line_ctl.sv
`timescale 1ns/1ps
module test_moesi_line_ctl;
    localparam int AW = 4;
    localparam int IW = 2;
    localparam int NS = 1 << IW;
    localparam int ST_I = 0, ST_S = 1, ST_E = 2, ST_O = 3, ST_M = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0, cpu_write = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ack, bus_req;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_gnt = 1'b0, bus_shared = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_cmd = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_shared, snp_supply;

    int checks = 0;
    int errors = 0;
    int m_st  [NS];
    int m_tag [NS];

    always #2.5 clk = ~clk;

    moesi_line_ctl #(.ADDR_W(AW), .IDX_W(IW)) i_moesi_line_ctl (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
        .cpu_ack(cpu_ack), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_shared(bus_shared),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_supply(snp_supply)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // one cycle: drive at the falling edge, compare, advance the model
    task automatic step(input string tag, input bit cv, input bit cw, input int ca,
                        input bit g, input bit sh, input bit sv, input int sc, input int sa);
        int ci, ct, si, stg, e_cmd, e_addr, n_st, n_tag;
        bit sact, e_sh, e_sup, cen, hit, e_ack, e_req, c_upd, s_upd;
        int s_n;
        @(negedge clk);
        cpu_valid = cv; cpu_write = cw; cpu_addr = AW'(ca);
        bus_gnt = g; bus_shared = sh;
        snp_valid = sv; snp_cmd = 2'(sc); snp_addr = AW'(sa);
        ci = ca % NS; ct = ca / NS; si = sa % NS; stg = sa / NS;
        sact  = sv && !g && m_st[si] != ST_I && m_tag[si] == stg && (sc == 0 || sc == 1);
        e_sh  = sact && sc == 0;
        e_sup = e_sh && (m_st[si] == ST_M || m_st[si] == ST_O);
        s_upd = 1'b0; s_n = m_st[si];
        if (sact) begin
            if (sc == 1) begin s_upd = 1'b1; s_n = ST_I; end
            else if (m_st[si] == ST_M) begin s_upd = 1'b1; s_n = ST_O; end
            else if (m_st[si] == ST_E) begin s_upd = 1'b1; s_n = ST_S; end
        end
        cen = cv && !(sact && si == ci);
        hit = m_st[ci] != ST_I && m_tag[ci] == ct;
        e_ack = 0; e_req = 0; e_cmd = 3; e_addr = 0; c_upd = 0;
        n_st = m_st[ci]; n_tag = m_tag[ci];
        if (cen) begin
            if (hit && (!cw || m_st[ci] == ST_M)) e_ack = 1;
            else if (hit && m_st[ci] == ST_E) begin e_ack = 1; c_upd = 1; n_st = ST_M; end
            else if (hit) begin
                e_req = 1; e_cmd = 1; e_addr = ca;
                if (g) begin e_ack = 1; c_upd = 1; n_st = ST_M; end
            end else if (m_st[ci] == ST_M || m_st[ci] == ST_O) begin
                e_req = 1; e_cmd = 2; e_addr = m_tag[ci] * NS + ci;
                if (g) begin c_upd = 1; n_st = ST_I; end
            end else begin
                e_req = 1; e_cmd = 0; e_addr = ca;
                if (g) begin c_upd = 1; n_st = sh ? ST_S : ST_E; n_tag = ct; e_ack = !cw; end
            end
        end
        #1;
        chk(tag, "cpu_ack", int'(cpu_ack), int'(e_ack));
        chk(tag, "bus_req", int'(bus_req), int'(e_req));
        chk(tag, "bus_cmd", int'(bus_cmd), e_cmd);
        chk(tag, "bus_addr", int'(bus_addr), e_addr);
        chk(tag, "snp_shared", int'(snp_shared), int'(e_sh));
        chk(tag, "snp_supply", int'(snp_supply), int'(e_sup));
        if (c_upd) begin m_st[ci] = n_st; m_tag[ci] = n_tag; end
        if (s_upd) m_st[si] = s_n;
    endtask

    task automatic snoop_rd(input string tag, input int a);
        step(tag, 0, 0, 0, 0, 0, 1, 0, a);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_st[i] = ST_I; m_tag[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        for (int a = 0; a < 16; a++) snoop_rd("R1", a);
        step("R1", 1, 0, 5, 0, 0, 0, 0, 0);
        // R2: read fill exclusive, then snoop read downgrades (R6)
        step("R2", 1, 0, 5, 1, 0, 0, 0, 0);
        step("R5", 1, 0, 5, 0, 0, 0, 0, 0);
        snoop_rd("R6", 5);
        // R4: write on Shared waits for grant
        step("R4", 1, 1, 5, 0, 0, 0, 0, 0);
        step("R4", 1, 1, 5, 1, 0, 0, 0, 0);
        step("R5", 1, 1, 5, 0, 0, 0, 0, 0);
        snoop_rd("R6", 5);
        snoop_rd("R6", 5);
        // R4: write on Owned
        step("R4", 1, 1, 5, 1, 0, 0, 0, 0);
        // R8: dirty victim written back, then refilled shared
        step("R8", 1, 0, 9, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 9, 1, 0, 0, 0, 0);
        step("R8", 1, 0, 9, 1, 1, 0, 0, 0);
        snoop_rd("R6", 9);
        // R7: snooped invalidate, next access misses
        step("R7", 0, 0, 0, 0, 0, 1, 1, 9);
        step("R7", 1, 0, 9, 0, 0, 0, 0, 0);
        snoop_rd("R7", 9);
        // R3: write miss as fill then write hit
        step("R3", 1, 1, 2, 1, 0, 0, 0, 0);
        step("R3", 1, 1, 2, 0, 0, 0, 0, 0);
        snoop_rd("R3", 2);
        step("R3", 1, 1, 6, 1, 0, 0, 0, 0);
        step("R3", 1, 1, 6, 1, 0, 0, 0, 0);
        step("R3", 1, 1, 6, 1, 1, 0, 0, 0);
        step("R3", 1, 1, 6, 0, 0, 0, 0, 0);
        step("R3", 1, 1, 6, 1, 0, 0, 0, 0);
        // R9: snoops ignored under grant, write-back snoop inert
        step("R9", 0, 0, 0, 1, 0, 1, 1, 6);
        step("R9", 0, 0, 0, 1, 0, 1, 0, 6);
        step("R9", 0, 0, 0, 0, 0, 1, 2, 6);
        snoop_rd("R9", 6);
        // R10: snoop on the same set holds off the local access
        step("R10", 1, 1, 6, 1, 0, 1, 1, 6);
        step("R10", 1, 0, 6, 0, 0, 0, 0, 0);
        step("R10", 1, 0, 6, 1, 0, 1, 0, 10);
        // R8: clean victim needs no write-back
        step("R8", 1, 0, 3, 1, 0, 0, 0, 0);
        step("R8", 1, 0, 7, 0, 0, 0, 0, 0);
        step("R8", 1, 0, 7, 1, 1, 0, 0, 0);
        // sweep over all addresses, operations and responses
        for (int n = 0; n < 6000; n++) begin
            step(n[0] ? "R6" : "R2",
                 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 2)), int'($urandom_range(0, 15)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule